// File: doc/BRIEF.md
# Asynchronous Bus Master Cycle Sequencer

This block runs single read and write transfers on an asynchronous, strobe-based 16-bit bus. That style of bus has no address bit 0 and two byte strobes. A requester presents a word address, a transfer size, a byte-lane choice for byte transfers, a direction and write data. The sequencer drives the address, the address strobe, the upper and lower data strobes, the read/write line and the per-lane output enables of the data bus. It then waits for the slave's active-low acknowledge. When the transfer completes it returns the captured read data with a one-cycle done pulse.

The sequencer runs on a clock at twice the bus processor rate, so each internal clock is one half-cycle state. A transfer without waits walks eight states, S0 to S7. The acknowledge is looked at only at the end of S4. If it is still high there, pairs of wait states are inserted, and the acknowledge is looked at again at the end of each pair. The acknowledge input must already be synchronous to `clk`.

In the requirements, the acceptance edge A is the rising edge at which `req_valid` is high while `busy` is low. "Cycle n" is the clock period that follows edge A+n. W is the number of wait pairs inserted. The done cycle is D = 7 + 2W.

Top module: `async_bus_master`

## Requirements
- R1: While reset is held, and right after it, `bus_as_n`, `bus_uds_n`, `bus_lds_n` and `bus_rw_n` are 1, and `bus_doe`, `rsp_done` and `busy` are 0. A reset in the middle of a transfer returns all of them to these values.
- R2: In a read, `bus_as_n` and the selected data strobes are low from cycle 2 through cycle D-1. They all return high together in cycle D. `rsp_done` is 1 only in cycle D. `busy` is 1 from cycle 0 through cycle D, and 0 in cycle D+1.
- R3: In a write, `bus_as_n` falls in cycle 2. `bus_rw_n` falls, and `bus_dout` carries the write data on the enabled lanes, in cycle 3. The selected data strobes fall in cycle 4. The strobes rise in cycle D. `bus_rw_n` stays low, and the lanes stay enabled, through cycle D. They are released in cycle D+1.
- R4: `bus_ack_n` is sampled at the end of cycle 4 and then at the end of cycle 6+2k for k = 0, 1, ... The first low sample at the end of cycle 4+2W gives W wait pairs. A low acknowledge at any other time has no effect.
- R5: Lane selection: bit 1 of `bus_doe`, and `bus_uds_n`, belong to data bits 15:8. Bit 0 and `bus_lds_n` belong to bits 7:0. With `req_word`=1 both lanes are used. With `req_word`=0, `req_upper`=1 selects only the high lane and `req_upper`=0 only the low lane.
- R6: A read captures `bus_din` as it stands in cycle D-1, on the selected lanes. Unselected lanes of `rsp_rdata` read as 0. The result is visible from cycle D and is held unchanged through later writes until the next read completes.
- R7: In a read, `bus_rw_n` stays 1 and `bus_doe` stays 0 for the whole transfer.
- R8: A request presented while `busy` is 1 is ignored. The address of the running transfer does not change, and no further transfer starts after it completes.
- R9: `rsp_done` is never high in two consecutive cycles.
- R10: `bus_addr` holds the accepted word address from cycle 0 through cycle D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-state clock (twice the bus processor rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken when `busy` is 0 |
| req_addr | input | ADDR_W | Word address (byte address bits above bit 0) |
| req_word | input | 1 | 1 = 16-bit transfer, 0 = byte transfer |
| req_upper | input | 1 | For byte transfers: 1 = high lane, 0 = low lane |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Transfer in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| bus_addr | output | ADDR_W | Bus word address |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_uds_n | output | 1 | High-lane data strobe, active low |
| bus_lds_n | output | 1 | Low-lane data strobe, active low |
| bus_rw_n | output | 1 | 1 = read, 0 = write |
| bus_dout | output | DATA_W | Data driven toward the slave |
| bus_doe | output | 2 | Per-lane output enable for `bus_dout` |
| bus_din | input | DATA_W | Data returned by the slave |
| bus_ack_n | input | 1 | Slave transfer acknowledge, active low, synchronous to `clk` |

## Verification
The hardest behaviour to reach from the ports is the way the acknowledge interacts with the sampling points. An acknowledge that arrives between two sampling points, or a short one that comes early and goes away again, must not shorten the transfer. The slave model in the bench therefore places the acknowledge in a chosen cycle, and can also add an early low pulse in cycles 2 and 3. It drives valid read data only in the one cycle in which the capture should happen, and the inverse value in every other cycle. A capture one cycle early or late therefore shows up in the returned data. A second request is injected while a long transfer is still waiting for its acknowledge, to show that it is ignored.

// File: rtl/asbm_pkg.sv
package asbm_pkg;

    // Two byte lanes: index 1 = bits 15:8, index 0 = bits 7:0
    localparam int unsigned LANES = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_S0,
        ST_S1,
        ST_S2,
        ST_S3,
        ST_S4,
        ST_W0,
        ST_W1,
        ST_S5,
        ST_S6,
        ST_S7
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       as_n;
        logic       uds_n;
        logic       lds_n;
        logic       rw_n;
        logic       drive;
        logic       done;
    } seq_regs_t;

    // Address strobe active window
    function automatic logic addr_phase(seq_state_e s);
        return s inside {ST_S2, ST_S3, ST_S4, ST_W0, ST_W1, ST_S5, ST_S6};
    endfunction

    // Data strobe window; a write starts it one full clock later
    function automatic logic data_phase(seq_state_e s, logic is_write);
        if (is_write) begin
            return s inside {ST_S4, ST_W0, ST_W1, ST_S5, ST_S6};
        end
        return addr_phase(s);
    endfunction

    // Write drive window: read/write low and data enabled
    function automatic logic drive_phase(seq_state_e s);
        return s inside {ST_S3, ST_S4, ST_W0, ST_W1, ST_S5, ST_S6, ST_S7};
    endfunction

endpackage

// File: rtl/asbm_lane_dec.sv
module asbm_lane_dec
    import asbm_pkg::*;
(
    input  logic             size_word,
    input  logic             pick_upper,
    output logic [LANES-1:0] lane_sel
);

    // R5: word uses both lanes, byte uses the one picked
    always_comb begin
        lane_sel[1] = size_word | pick_upper;
        lane_sel[0] = size_word | ~pick_upper;
    end

endmodule

// File: rtl/asbm_seq.sv
module asbm_seq
    import asbm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             xfer_write,
    input  logic [LANES-1:0] xfer_lanes,
    input  logic             ack_n,
    output logic             accept,
    output logic             capture,
    output logic             busy,
    output logic             as_n,
    output logic             uds_n,
    output logic             lds_n,
    output logic             rw_n,
    output logic             drive,
    output logic             done
);

    seq_regs_t seq_q, seq_d;
    seq_state_e nxt;
    logic ds_on;

    always_comb begin
        accept  = req_valid && (seq_q.state == ST_IDLE);
        capture = (seq_q.state == ST_S6);
        busy    = (seq_q.state != ST_IDLE);

        nxt = seq_q.state;
        unique case (seq_q.state)
            ST_IDLE: if (req_valid) nxt = ST_S0;
            ST_S0:   nxt = ST_S1;
            ST_S1:   nxt = ST_S2;
            ST_S2:   nxt = ST_S3;
            ST_S3:   nxt = ST_S4;
            ST_S4:   nxt = ack_n ? ST_W0 : ST_S5;
            ST_W0:   nxt = ST_W1;
            ST_W1:   nxt = ack_n ? ST_W0 : ST_S5;
            ST_S5:   nxt = ST_S6;
            ST_S6:   nxt = ST_S7;
            ST_S7:   nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase

        ds_on         = data_phase(nxt, xfer_write);
        seq_d         = seq_q;
        seq_d.state   = nxt;
        seq_d.as_n    = ~addr_phase(nxt);
        seq_d.uds_n   = ~(ds_on & xfer_lanes[1]);
        seq_d.lds_n   = ~(ds_on & xfer_lanes[0]);
        seq_d.drive   = xfer_write & drive_phase(nxt);
        seq_d.rw_n    = ~seq_d.drive;
        seq_d.done    = (nxt == ST_S7);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, as_n: 1'b1, uds_n: 1'b1, lds_n: 1'b1,
                       rw_n: 1'b1, drive: 1'b0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign as_n  = seq_q.as_n;
    assign uds_n = seq_q.uds_n;
    assign lds_n = seq_q.lds_n;
    assign rw_n  = seq_q.rw_n;
    assign drive = seq_q.drive;
    assign done  = seq_q.done;

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    strobes_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(as_n) |-> (uds_n && lds_n && done));

    // R2
    read_strobe_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(as_n) && !xfer_write) |-> (!uds_n || !lds_n));

    // R3
    write_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(as_n) && xfer_write) |-> (uds_n && lds_n && rw_n));

    // R3
    write_ds_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($fell(uds_n) || $fell(lds_n)) && xfer_write)
            |-> ($past(as_n, 2) == 1'b0 && $past(as_n, 3) == 1'b1));

    // R3
    rw_after_as_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rw_n) |-> (!as_n && !$past(as_n)));

    // R7
    rw_read_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rw_n |-> xfer_write);

    // R5
    upper_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !uds_n |-> xfer_lanes[1]);

    // R5
    lower_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lds_n |-> xfer_lanes[0]);

endmodule

// File: rtl/asbm_data.sv
module asbm_data
    import asbm_pkg::*;
#(
    parameter int unsigned ADDR_W = 23,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic              drive,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic [LANES-1:0]  req_lanes,
    input  logic [DATA_W-1:0] bus_din,
    output logic              xfer_write,
    output logic [LANES-1:0]  xfer_lanes,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic [LANES-1:0]  bus_doe,
    output logic [DATA_W-1:0] rsp_rdata
);

    localparam int unsigned LANE_W = DATA_W / LANES;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              write;
        logic [LANES-1:0]  lanes;
        logic [DATA_W-1:0] rdata;
    } dp_regs_t;

    dp_regs_t dp_q, dp_d;
    logic [LANE_W-1:0] din_lane [LANES];

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign din_lane[g] = bus_din[g*LANE_W +: LANE_W];
            assign bus_doe[g]  = drive & dp_q.lanes[g];
        end
    endgenerate

    always_comb begin
        dp_d = dp_q;
        if (accept) begin
            dp_d.addr  = req_addr;
            dp_d.wdata = req_wdata;
            dp_d.write = req_write;
            dp_d.lanes = req_lanes;
        end
        if (capture && !dp_q.write) begin
            for (int i = 0; i < LANES; i++) begin
                dp_d.rdata[i*LANE_W +: LANE_W] =
                    dp_q.lanes[i] ? din_lane[i] : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign xfer_write = dp_q.write;
    assign xfer_lanes = dp_q.lanes;
    assign bus_addr   = dp_q.addr;
    assign bus_dout   = dp_q.wdata;
    assign rsp_rdata  = dp_q.rdata;

    // R7
    read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dp_q.write |-> (bus_doe == '0));

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive && $past(drive)) |-> $stable(bus_addr));

endmodule

// File: rtl/async_bus_master.sv
module async_bus_master
    import asbm_pkg::*;
#(
    parameter int unsigned ADDR_W = 23,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_word,
    input  logic              req_upper,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_as_n,
    output logic              bus_uds_n,
    output logic              bus_lds_n,
    output logic              bus_rw_n,
    output logic [DATA_W-1:0] bus_dout,
    output logic [1:0]        bus_doe,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              bus_ack_n
);

    logic [LANES-1:0] req_lanes;
    logic [LANES-1:0] xfer_lanes;
    logic             xfer_write;
    logic             accept;
    logic             capture;
    logic             drive;

    asbm_lane_dec i_lane_dec (
        .size_word  (req_word),
        .pick_upper (req_upper),
        .lane_sel   (req_lanes)
    );

    asbm_seq i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .xfer_write (xfer_write),
        .xfer_lanes (xfer_lanes),
        .ack_n      (bus_ack_n),
        .accept     (accept),
        .capture    (capture),
        .busy       (busy),
        .as_n       (bus_as_n),
        .uds_n      (bus_uds_n),
        .lds_n      (bus_lds_n),
        .rw_n       (bus_rw_n),
        .drive      (drive),
        .done       (rsp_done)
    );

    asbm_data #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .capture    (capture),
        .drive      (drive),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_write  (req_write),
        .req_lanes  (req_lanes),
        .bus_din    (bus_din),
        .xfer_write (xfer_write),
        .xfer_lanes (xfer_lanes),
        .bus_addr   (bus_addr),
        .bus_dout   (bus_dout),
        .bus_doe    (bus_doe),
        .rsp_rdata  (rsp_rdata)
    );

endmodule

// File: tb/test_async_bus_master.sv
module test_async_bus_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [22:0] req_addr = '0;
    logic        req_word = 1'b0;
    logic        req_upper = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        busy;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic [22:0] bus_addr;
    logic        bus_as_n;
    logic        bus_uds_n;
    logic        bus_lds_n;
    logic        bus_rw_n;
    logic [15:0] bus_dout;
    logic [1:0]  bus_doe;
    logic [15:0] bus_din = '0;
    logic        bus_ack_n = 1'b1;

    int tests = 0;
    int fails = 0;
    logic [15:0] last_rd = '0;

    always #10 clk = ~clk;

    async_bus_master i_async_bus_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_word(req_word), .req_upper(req_upper), .req_write(req_write),
        .req_wdata(req_wdata), .busy(busy), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .bus_addr(bus_addr), .bus_as_n(bus_as_n),
        .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n), .bus_rw_n(bus_rw_n),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
        .bus_ack_n(bus_ack_n)
    );

    typedef struct packed {
        logic        wr;
        logic        word;
        logic        upper;
        logic        early;
        logic        poke;
        logic [3:0]  ack_from;
        logic [22:0] addr;
        logic [15:0] wdata;
        logic [15:0] din;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  23'h000400, 16'h0000, 16'hA55A},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4,  23'h7FFFFF, 16'h0000, 16'h3C96},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5,  23'h123456, 16'h0000, 16'hBEEF},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4,  23'h000001, 16'h1234, 16'h0000},
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8,  23'h2AAAAA, 16'hCAFE, 16'h0000},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  23'h555555, 16'h00FF, 16'h0000},
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd6,  23'h0F0F0F, 16'h0000, 16'h6D21},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd10, 23'h400000, 16'h0000, 16'h9E07}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] idle_vec();
        // {as, uds, lds, rw, doe[1:0], done, busy}
        return 8'b1111_0000;
    endfunction

    task automatic run_vec(input vec_t v);
        int w;
        int dd;
        logic [1:0] ln;
        logic [15:0] exp_rd;
        logic ds;
        logic [7:0] exp_v;
        string tag;
        ln = {v.word | v.upper, v.word | ~v.upper};
        w = (v.ack_from <= 4) ? 0 : (int'(v.ack_from) - 3) / 2;
        dd = 7 + 2 * w;
        exp_rd = {ln[1] ? v.din[15:8] : 8'h00, ln[0] ? v.din[7:0] : 8'h00};
        tag = v.wr ? "R3 R4 R5" : "R2 R4 R5 R7";

        @(negedge clk);
        req_valid = 1'b1; req_addr = v.addr; req_word = v.word;
        req_upper = v.upper; req_write = v.wr; req_wdata = v.wdata;
        bus_ack_n = 1'b1;
        @(posedge clk);
        for (int k = 0; k <= dd + 1; k++) begin
            @(negedge clk);
            if (k == 0) req_valid = 1'b0;
            if (v.poke && k == 3) begin
                req_valid = 1'b1; req_addr = ~v.addr; req_write = ~v.wr;
            end
            if (v.poke && k == 4) req_valid = 1'b0;
            ds = v.wr ? (k >= 4 && k <= dd - 1) : (k >= 2 && k <= dd - 1);
            exp_v = {(k >= 2 && k <= dd - 1) ? 1'b0 : 1'b1,
                     ~(ds & ln[1]), ~(ds & ln[0]),
                     ~(v.wr && k >= 3 && k <= dd),
                     (v.wr && k >= 3 && k <= dd) ? ln : 2'b00,
                     k == dd, k <= dd};
            chk(tag, {24'h0, bus_as_n, bus_uds_n, bus_lds_n, bus_rw_n, bus_doe,
                      rsp_done, busy}, {24'h0, exp_v});
            if (k <= dd) chk(v.poke ? "R8 R10" : "R10", {9'h0, bus_addr}, {9'h0, v.addr});
            if (v.wr && k == 3) chk("R3", {16'h0, bus_dout}, {16'h0, v.wdata});
            if (k == dd) chk("R6", {16'h0, rsp_rdata}, {16'h0, v.wr ? last_rd : exp_rd});
            // slave model for the window following this edge
            bus_ack_n = ~((k >= v.ack_from && k <= dd - 1) || (v.early && (k == 2 || k == 3)));
            bus_din = (k == 6 + 2 * w) ? v.din : ~v.din;
        end
        bus_ack_n = 1'b1;
        if (!v.wr) last_rd = exp_rd;
        if (v.poke) begin
            for (int j = 0; j < 3; j++) begin
                @(negedge clk);
                chk("R8", {31'h0, busy}, 32'h0);
            end
        end
    endtask

    task automatic check_done_single();
        int hi;
        hi = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (rsp_done) hi++;
        end
        chk("R9", hi, 1);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", {24'h0, bus_as_n, bus_uds_n, bus_lds_n, bus_rw_n, bus_doe, rsp_done, busy},
            {24'h0, idle_vec()});
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {24'h0, bus_as_n, bus_uds_n, bus_lds_n, bus_rw_n, bus_doe, rsp_done, busy},
            {24'h0, idle_vec()});

        for (int n = 0; n < NVEC; n++) begin
            run_vec(VECS[n]);
        end

        // R9: count done cycles across one zero-wait read
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_word = 1'b1; bus_ack_n = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check_done_single();
        bus_ack_n = 1'b1;

        // R1: reset in the middle of a write
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_word = 1'b1; req_addr = 23'h0000AA;
        @(posedge clk);
        repeat (4) @(negedge clk);
        req_valid = 1'b0;
        chk("R1", {31'h0, bus_rw_n}, 32'h0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", {24'h0, bus_as_n, bus_uds_n, bus_lds_n, bus_rw_n, bus_doe, rsp_done, busy},
            {24'h0, idle_vec()});
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", {31'h0, busy}, 32'h0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule